// File: doc/BRIEF.md
# Three-Wire Control Bus Register Slave

This block is the register-side endpoint of a three-wire serial control bus. It has a bus clock, a bidirectional data line and a mode line. The mode line picks the phase. While it is low, the slave collects a device byte that carries a 6-bit identity and a 2-bit operation code. While it is high, the slave moves data bytes: a register-selector byte, then register contents. A read takes two transactions. The first names the register to be read. The second returns an echo of that register address with a validity flag, followed by the register value.

All bus inputs are brought into the system clock domain through synchronizers. Bus-clock edges are found by comparing successive synchronized samples, so the bus clock must be several times slower than `clk`. The data line is modelled as a separate input, output and output enable. Pad logic outside the block combines them.

The control state machine (`twc_state_e`) has seven states:
- `ST_ADDR`: the address phase.
- `ST_SKIP`: a data phase that is ignored.
- `ST_WREG`: waiting for the selector byte.
- `ST_WDATA`: collecting register bytes.
- `ST_WDONE`: further bytes are ignored.
- `ST_RSEND`: driving the read frame.
- `ST_RDONE`: the read frame is finished.

Transitions:
- A falling mode line always leads to `ST_ADDR`.
- A rising mode line leads to `ST_WREG` for a matched write code, to `ST_RSEND` for a matched read code, and to `ST_SKIP` otherwise.
- In `ST_WREG`, a completed selector byte leads to `ST_WDATA` when bit 0 is 0, or to `ST_WDONE` when bit 0 is 1.
- In `ST_WDATA`, the last data byte leads to `ST_WDONE`.
- In `ST_RSEND`, the falling bus-clock edge after the last frame bit leads to `ST_RDONE`.

Top module: `twc_slave`

## Requirements
- R1: A high mode line is the data phase and a low mode line is the address phase. Every change of mode level restarts bit counting, so a byte is always the next eight rising bus-clock edges after the change.
- R2: The last complete byte received in the address phase is the device byte. The slave takes part in the following data phase only if that byte's bits [7:2] equal 6'b010100. With any other identity, the data phase changes no register, no pointer and drives nothing.
- R3: Bits [1:0] of the device byte are the operation code. 2'b10 (bit 1 = 1, bit 0 = 0) means write or prepare-read. 2'b11 means read. 2'b00 and 2'b01 are unused: that data phase changes nothing and drives nothing.
- R4: With code 2'b10, the first data byte is the selector. If its bit 0 is 0, bits [7:1] name the target register. The next two bytes are the new value, most significant byte first. The register takes the new value when the second byte completes. Any later bytes in the same data phase are ignored.
- R5: A selector byte with bit 0 = 1 stores bits [7:1] as the read pointer and changes no register.
- R6: With code 2'b11, the slave sends a 24-bit frame. Byte 0 is {pointer[6:0], flag}. Byte 1 is bits [15:8] of the pointed register. Byte 2 is bits [7:0].
- R7: Addresses 0 to 31 are implemented. For those, the flag is 0 and the stored value is returned. For addresses 32 to 127, the flag is 1, the data bytes read as zero, and writes are discarded.
- R8: Bytes go least significant bit first. The slave samples the data line on the rising bus-clock edge. When driving, it changes the line only after a falling edge. The first bit is on the line from the start of the read data phase.
- R9: The output enable is high only while a read frame is being sent. It drops after the falling edge that follows the 24th bit, or when the mode line falls, whichever comes first.
- R10: After reset, all registers and the pointer are zero, the output enable is low and the data output is 0.
- R11: A write whose data phase ends before its last data byte completes leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Serial bus clock |
| bus_mode_i | input | 1 | Phase select: low is address phase, high is data phase |
| bus_dat_i | input | 1 | Serial data received from the bus |
| bus_dat_o | output | 1 | Serial data driven onto the bus |
| bus_dat_oe | output | 1 | Enable for the data-line driver |

## Verification
The hardest condition to reach is an implemented register that is changed by a write that looked invalid. This can happen because addresses 32 to 127 alias onto the low index bits of the 32-entry store. The bench therefore first fills every implemented register with a distinct value computed from its address. It then issues writes to 32, 64 and 127, and finally reads back all 128 addresses with a prepare and read pair for each. A second hard case is a device byte misaligned by stray address-phase bits. To reach it, the bench clocks three junk bits and toggles the mode line before a real transaction, then confirms that the register changes as intended.

// File: rtl/twc_pkg.sv
package twc_pkg;

    typedef enum logic [2:0] {
        ST_ADDR,
        ST_SKIP,
        ST_WREG,
        ST_WDATA,
        ST_WDONE,
        ST_RSEND,
        ST_RDONE
    } twc_state_e;

    localparam logic [1:0] OPM_WRITE = 2'b10;
    localparam logic [1:0] OPM_READ  = 2'b11;

endpackage

// File: rtl/twc_sync.sv
module twc_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o
);

    logic [N-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= raw_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign lvl_o = stg_q[STAGES-1];

endmodule

// File: rtl/twc_rx.sv
module twc_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       sample_i,
    input  logic       din_i,
    output logic [7:0] byte_o,
    output logic       byte_done_o
);

    logic [6:0] sh_q;
    logic [2:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (sample_i) begin
            sh_q  <= {din_i, sh_q[6:1]};
            cnt_q <= cnt_q + 3'd1;
        end
    end

    assign byte_o      = {din_i, sh_q};
    assign byte_done_o = sample_i && !clear_i && (cnt_q == 3'd7);

    // R1: a completed byte needs eight samples since the last restart
    p_byte_after_eight_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_o |=> (cnt_q == 3'd0));

endmodule

// File: rtl/twc_regfile.sv
module twc_regfile #(
    parameter int W      = 16,
    parameter int ADDR_W = 7,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [W-1:0]      rdata_o,
    output logic              rvalid_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (32'(waddr_i) == i) mem_q[i] <= wdata_i;
            end
        end
    end

    assign rvalid_o = 32'(raddr_i) < 32'(DEPTH);
    assign rdata_o  = rvalid_o ? mem_q[raddr_i[IDX_W-1:0]] : '0;

endmodule

// File: rtl/twc_slave.sv
module twc_slave
    import twc_pkg::*;
#(
    parameter logic [5:0] DEV_ID      = 6'b010100,
    parameter int         REG_W       = 16,
    parameter int         ADDR_W      = 7,
    parameter int         NUM_IMPL    = 32,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk_i,
    input  logic bus_mode_i,
    input  logic bus_dat_i,
    output logic bus_dat_o,
    output logic bus_dat_oe
);

    localparam int NBYTES  = REG_W / 8;
    localparam int FRAME_W = 8 + REG_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int BI_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int WBUF_W  = REG_W - 8;

    // ---- synchronizers and edge detection
    logic [2:0] lvl;
    logic       clk_s, mode_s, dat_s;
    logic       clk_p, mode_p;
    logic       clk_rise, clk_fall, mode_rise, mode_fall;

    twc_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({bus_dat_i, bus_mode_i, bus_clk_i}),
        .lvl_o (lvl)
    );

    assign {dat_s, mode_s, clk_s} = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_p  <= 1'b0;
            mode_p <= 1'b0;
        end else begin
            clk_p  <= clk_s;
            mode_p <= mode_s;
        end
    end

    assign clk_rise  = clk_s & ~clk_p;
    assign clk_fall  = ~clk_s & clk_p;
    assign mode_rise = mode_s & ~mode_p;
    assign mode_fall = ~mode_s & mode_p;

    // ---- byte receiver
    logic [7:0] rx_byte;
    logic       byte_done;

    twc_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (mode_rise | mode_fall),
        .sample_i    (clk_rise),
        .din_i       (dat_s),
        .byte_o      (rx_byte),
        .byte_done_o (byte_done)
    );

    // ---- state and datapath registers
    twc_state_e          state_q, state_d;
    logic [7:0]          dev_byte_q;
    logic                dev_ok_q;
    logic [ADDR_W-1:0]   reg_addr_q;
    logic [ADDR_W-1:0]   ptr_q;
    logic [WBUF_W-1:0]   wbuf_q;
    logic [BI_W-1:0]     byte_idx_q;
    logic [FRAME_W-1:0]  tx_sh_q;
    logic [CNT_W-1:0]    tx_cnt_q;
    logic                oe_q;

    logic                dev_match;
    logic                last_byte;
    logic                reg_we;
    logic [REG_W-1:0]    reg_wdata;
    logic [REG_W-1:0]    rd_data;
    logic                rd_valid;
    logic [FRAME_W-1:0]  tx_frame;

    assign dev_match = dev_ok_q && (dev_byte_q[7:2] == DEV_ID);
    assign last_byte = (byte_idx_q == BI_W'(NBYTES - 1));
    assign reg_we    = (state_q == ST_WDATA) && byte_done && last_byte;
    assign reg_wdata = {wbuf_q, rx_byte};

    twc_regfile #(.W(REG_W), .ADDR_W(ADDR_W), .DEPTH(NUM_IMPL)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we),
        .waddr_i  (reg_addr_q),
        .wdata_i  (reg_wdata),
        .raddr_i  (ptr_q),
        .rdata_o  (rd_data),
        .rvalid_o (rd_valid)
    );

    // read frame: echo byte first, then register bytes high to low
    always_comb begin
        tx_frame[7:0] = {ptr_q, ~rd_valid};
        for (int i = 0; i < NBYTES; i++) begin
            tx_frame[8 + 8*i +: 8] = rd_data[REG_W - 8 - 8*i +: 8];
        end
    end

    // ---- next-state logic
    always_comb begin
        state_d = state_q;
        if (mode_fall) begin
            state_d = ST_ADDR;
        end else if (mode_rise) begin
            if (dev_match && dev_byte_q[1:0] == OPM_WRITE)     state_d = ST_WREG;
            else if (dev_match && dev_byte_q[1:0] == OPM_READ) state_d = ST_RSEND;
            else                                               state_d = ST_SKIP;
        end else begin
            unique case (state_q)
                ST_WREG:  if (byte_done) state_d = rx_byte[0] ? ST_WDONE : ST_WDATA;
                ST_WDATA: if (byte_done && last_byte) state_d = ST_WDONE;
                ST_RSEND: if (clk_fall && tx_cnt_q == CNT_W'(FRAME_W - 1)) state_d = ST_RDONE;
                ST_ADDR, ST_SKIP, ST_WDONE, ST_RDONE: state_d = state_q;
                default:  state_d = ST_ADDR;
            endcase
        end
    end

    // ---- state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ADDR;
        else        state_q <= state_d;
    end

    // ---- datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_byte_q <= '0;
            dev_ok_q   <= 1'b0;
            reg_addr_q <= '0;
            ptr_q      <= '0;
            wbuf_q     <= '0;
            byte_idx_q <= '0;
            tx_sh_q    <= '0;
            tx_cnt_q   <= '0;
            oe_q       <= 1'b0;
        end else if (mode_fall) begin
            dev_ok_q <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            if (state_q == ST_ADDR && !mode_s && byte_done) begin
                dev_byte_q <= rx_byte;
                dev_ok_q   <= 1'b1;
            end
            if (mode_rise && state_d == ST_RSEND) begin
                tx_sh_q  <= tx_frame;
                tx_cnt_q <= '0;
                oe_q     <= 1'b1;
            end
            if (state_q == ST_RSEND && clk_fall) begin
                tx_sh_q  <= tx_sh_q >> 1;
                tx_cnt_q <= tx_cnt_q + CNT_W'(1);
                if (tx_cnt_q == CNT_W'(FRAME_W - 1)) oe_q <= 1'b0;
            end
            if (state_q == ST_WREG && byte_done) begin
                if (rx_byte[0]) ptr_q      <= rx_byte[7:1];
                else            reg_addr_q <= rx_byte[7:1];
                byte_idx_q <= '0;
            end
            if (state_q == ST_WDATA && byte_done) begin
                wbuf_q     <= WBUF_W'({wbuf_q, rx_byte});
                byte_idx_q <= byte_idx_q + BI_W'(1);
            end
        end
    end

    assign bus_dat_oe = oe_q;
    assign bus_dat_o  = oe_q & tx_sh_q[0];

    // ---- assertions
    // R9: driver enabled only while a read frame is in flight
    p_oe_only_sending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dat_oe |-> (state_q == ST_RSEND));

    // R9: a falling mode line releases the data line
    p_release_on_mode_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fall |=> !bus_dat_oe);

    // R8: the driven bit only moves after a falling bus-clock edge
    p_dout_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dat_oe && !clk_fall && !mode_fall) |=> $stable(bus_dat_o));

    // R2: register writes need a matching identity and write code
    p_write_needs_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (dev_byte_q[7:2] == DEV_ID && dev_byte_q[1:0] == OPM_WRITE));

    // R3: ignored phases never drive
    p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !bus_dat_oe);

    // R6: frame counter stays inside the frame while driving
    p_frame_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dat_oe |-> (tx_cnt_q < CNT_W'(FRAME_W)));

endmodule

// File: tb/twc_slave_tb.sv
module twc_slave_tb;

    localparam int H        = 5;       // bus half period in system clocks
    localparam int NIMPL    = 32;
    localparam int WDOG_CYC = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0;
    logic bmode = 1'b0;
    logic bdat = 1'b0;
    logic dout, doe;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    twc_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_clk_i  (bclk),
        .bus_mode_i (bmode),
        .bus_dat_i  (bdat),
        .bus_dat_o  (dout),
        .bus_dat_oe (doe)
    );

    function automatic logic [15:0] fval(input int a);
        return 16'((a * 16'h0B1D) ^ 16'h5AC3);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        bdat = b;
        wcyc(H);
        bclk = 1'b1;
        wcyc(H);
        bclk = 1'b0;
    endtask

    task automatic byte_out(input logic [7:0] b);
        for (int i = 0; i < 8; i++) bit_out(b[i]);
    endtask

    task automatic byte_in(output logic [7:0] b, inout logic oe_all);
        for (int i = 0; i < 8; i++) begin
            wcyc(H);
            b[i]   = dout;
            oe_all = oe_all & doe;
            bclk = 1'b1;
            wcyc(H);
            bclk = 1'b0;
        end
    endtask

    task automatic start_txn(input logic [7:0] dev);
        bmode = 1'b0;
        wcyc(2*H);
        byte_out(dev);
        wcyc(2*H);
        bmode = 1'b1;
        wcyc(2*H);
    endtask

    task automatic end_txn();
        wcyc(2*H);
        bmode = 1'b0;
        wcyc(2*H);
    endtask

    // write: selector bit 0 = 0, value MSB byte first
    task automatic wr(input logic [7:0] dev, input logic [6:0] a, input logic [15:0] v);
        start_txn(dev);
        byte_out({a, 1'b0});
        byte_out(v[15:8]);
        byte_out(v[7:0]);
        end_txn();
    endtask

    task automatic prep(input logic [7:0] dev, input logic [6:0] a);
        start_txn(dev);
        byte_out({a, 1'b1});
        end_txn();
    endtask

    task automatic rd_chk(input logic [7:0] echo, input logic [15:0] v, input string req);
        logic [7:0] b;
        logic oe_all;
        start_txn(8'h53);
        oe_all = 1'b1;
        byte_in(b, oe_all);
        chk({req, " echo"}, {23'd0, oe_all, b}, {23'd0, 1'b1, echo});
        oe_all = 1'b1;
        byte_in(b, oe_all);
        chk({req, " msb"}, {23'd0, oe_all, b}, {23'd0, 1'b1, v[15:8]});
        oe_all = 1'b1;
        byte_in(b, oe_all);
        chk({req, " lsb"}, {23'd0, oe_all, b}, {23'd0, 1'b1, v[7:0]});
        wcyc(2*H);
        chk("R9 release after frame", {31'd0, doe}, 32'd0);
        end_txn();
    endtask

    task automatic read_at(input int a, input string req);
        logic [15:0] v;
        prep(8'h52, 7'(a));
        v = (a < NIMPL) ? fval(a) : 16'h0000;
        rd_chk({7'(a), (a >= NIMPL)}, v, req);
    endtask

    task automatic nodrive(input logic [7:0] dev, input string req);
        logic any_oe;
        start_txn(dev);
        any_oe = 1'b0;
        for (int i = 0; i < 24; i++) begin
            wcyc(H);
            any_oe = any_oe | doe;
            bclk = 1'b1;
            wcyc(H);
            bclk = 1'b0;
        end
        chk(req, {31'd0, any_oe}, 32'd0);
        end_txn();
    endtask

    initial begin
        wcyc(WDOG_CYC);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic oe_all;
        wcyc(4);
        rst_n = 1'b1;
        wcyc(4);

        // R10: reset state at the ports
        chk("R10 oe after reset", {31'd0, doe}, 32'd0);
        chk("R10 dout after reset", {31'd0, dout}, 32'd0);
        // R10/R6: pointer 0, register 0 zero, echo valid
        rd_chk(8'h00, 16'h0000, "R10 read at reset pointer");

        // R4: fill implemented registers
        for (int a = 0; a < NIMPL; a++) wr(8'h52, 7'(a), fval(a));
        // R7: writes to unimplemented addresses are dropped (they alias low indices)
        wr(8'h52, 7'd32, 16'hDEAD);
        wr(8'h52, 7'd64, 16'hBEEF);
        wr(8'h52, 7'd127, 16'hFFFF);

        // R5 R6 R7 R8: sweep every address
        for (int a = 0; a < 128; a++) read_at(a, "R7 sweep R6 R8");

        // R2: wrong identity write ignored, and no drive on a read code
        wr(8'h92, 7'd3, 16'h1111);
        read_at(3, "R2 foreign identity write");
        nodrive(8'h93, "R2 foreign identity read drives");
        // R2: wrong identity prepare leaves pointer
        prep(8'h52, 7'd7);
        prep(8'hD2, 7'd9);
        rd_chk({7'd7, 1'b0}, fval(7), "R2 pointer kept");

        // R3: unused codes
        wr(8'h50, 7'd4, 16'h2222);
        wr(8'h51, 7'd4, 16'h3333);
        read_at(4, "R3 unused code write");
        nodrive(8'h50, "R3 unused code 00 drives");
        nodrive(8'h51, "R3 unused code 01 drives");

        // R4: extra bytes ignored
        start_txn(8'h52);
        byte_out({7'd5, 1'b0});
        byte_out(8'h12);
        byte_out(8'h34);
        byte_out(8'h56);
        byte_out(8'h78);
        end_txn();
        prep(8'h52, 7'd5);
        rd_chk({7'd5, 1'b0}, 16'h1234, "R4 trailing bytes");

        // R11: truncated write
        start_txn(8'h52);
        byte_out({7'd6, 1'b0});
        byte_out(8'hAB);
        end_txn();
        read_at(6, "R11 truncated write");

        // R1: stray bits then mode toggle restarts framing
        bmode = 1'b0;
        wcyc(2*H);
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
        wcyc(2*H);
        bmode = 1'b1;
        wcyc(4*H);
        wr(8'h52, 7'd8, 16'hC0DE);
        prep(8'h52, 7'd8);
        rd_chk({7'd8, 1'b0}, 16'hC0DE, "R1 framing restart");

        // R9: mode falls mid-frame
        prep(8'h52, 7'd9);
        start_txn(8'h53);
        oe_all = 1'b1;
        byte_in(b, oe_all);
        chk("R9 echo before abort", {23'd0, oe_all, b}, {23'd0, 1'b1, 7'd9, 1'b0});
        bmode = 1'b0;
        wcyc(2*H);
        chk("R9 release on mode fall", {31'd0, doe}, 32'd0);
        wcyc(2*H);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule